// File: doc/BRIEF.md
# Scan-Driven Console Byte Exchange

This block sits behind one data register of a test access port and moves console characters between a debug host and on-chip software. The scan side sees the usual strobes: capture, shift and update. It also sees a select line and the serial data bits. The target side has a receive queue, which carries bytes from the host to the target, and a transmit queue, which carries bytes from the target to the host. Each queue holds up to eight bytes.

Every scan moves a 72-bit payload, least significant bit first. The payload is one header byte followed by eight data bytes.
- **Outbound header:** the upper nibble is the number of bytes the host may take, and the lower nibble is the free space in the receive queue.
- **Inbound header:** the upper nibble says how many of the host's data bytes are valid.

Each scan therefore carries flow-control counts in both directions along with the data. A framing mode lets several devices share one chain. In that mode the inbound payload waits behind a leading start bit, and any bits after the payload are discarded.

Top module: `jsp_console_link`

## Requirements
- R1: After reset the receive side shows no valid byte, the transmit side is ready, and the first captured header is 0x08: no bytes available and a free space of 8.
- R2: On capture, the outbound header is latched. Bits [7:4] hold min(transmit count, 8) and bits [3:0] hold the receive free space. tdo_o presents header bit 0 before the first shift and one further bit on each shift.
- R3: The outbound data byte j (payload bits 8+8j to 15+8j) is the j-th oldest transmit byte. Slots beyond the available count read as 0x00.
- R4: At update of a complete frame, the first n inbound data bytes are appended to the receive queue in order. n is min(header bits [7:4], 8).
- R5: If n exceeds the receive free space, only the bytes that fit are accepted and the rest are dropped. A count field of 15 is treated as 8.
- R6: Transmit bytes are removed only at update of a complete frame. Exactly the number reported in the captured header is removed.
- R7: If fewer than 72 payload bits were shifted since capture, update changes neither queue.
- R8: With multi_i high, inbound bits are ignored until the first 1 bit. That start bit is not part of the payload. The outbound stream is not delayed.
- R9: Inbound bits beyond the 72nd payload bit are ignored.
- R10: Capture, shift and update strobes have no effect while sel_i is low.
- R11: The receive queue delivers bytes in order through rx_valid_o/rx_ready_i. When the transmit queue holds 8 bytes, tx_ready_o is low and tx_valid_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| multi_i | input | 1 | 1: wait for a start bit before counting payload |
| sel_i | input | 1 | This data register is selected |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data from host |
| tdo_o | output | 1 | Serial data to host |
| rx_data_o | output | 8 | Oldest host byte |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_ready_i | input | 1 | Target takes rx_data_o |
| tx_data_i | input | 8 | Byte from target |
| tx_valid_i | input | 1 | Target offers tx_data_i |
| tx_ready_o | output | 1 | Transmit queue has space |

## Verification
The assertions check on every cycle that:
- neither queue changes occupancy unless a committed update or a target-side transfer occurs;
- occupancy never exceeds the depth;
- the transmit queue is never asked to release more bytes than it holds;
- the first bit on tdo_o after capture is the free-space bit that was present at capture.

Only the bench scenarios can show the rest: byte order through both queues, the clamping of counts to the free space, start-bit alignment and trailing-bit rejection in multi-device framing, and the discarding of truncated frames.

// File: rtl/jsp_pkg.sv
package jsp_pkg;
  localparam int unsigned NIB_W = 4;
  typedef logic [7:0] byte_t;

  function automatic logic [NIB_W-1:0] nib_min(input logic [NIB_W-1:0] a,
                                               input logic [NIB_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/jsp_rx_fifo.sv
module jsp_rx_fifo
  import jsp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SLOTS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NIB_W-1:0]            push_n_i,
  input  logic [SLOTS-1:0][7:0]       push_bytes_i,
  input  logic                        pop_i,
  output byte_t                       head_o,
  output logic [NIB_W-1:0]            count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PW-1:0] wrap(input int unsigned v);
    return PW'(v % DEPTH);
  endfunction

  byte_t          mem [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [NIB_W-1:0] count_q;
  logic           pop_do;

  assign pop_do  = pop_i && (count_q != '0);
  assign head_o  = mem[rd_ptr];
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
    end else begin
      for (int i = 0; i < int'(SLOTS); i++)
        if (NIB_W'(i) < push_n_i)
          mem[wrap(int'(wr_ptr) + i)] <= push_bytes_i[i];
      wr_ptr  <= wrap(int'(wr_ptr) + int'(push_n_i));
      if (pop_do) rd_ptr <= wrap(int'(rd_ptr) + 1);
      count_q <= count_q + push_n_i - NIB_W'(pop_do);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= NIB_W'(DEPTH));
endmodule

// File: rtl/jsp_tx_fifo.sv
module jsp_tx_fifo
  import jsp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SLOTS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  byte_t                       push_data_i,
  input  logic [NIB_W-1:0]            pop_n_i,
  output logic [SLOTS-1:0][7:0]       peek_o,
  output logic [NIB_W-1:0]            count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PW-1:0] wrap(input int unsigned v);
    return PW'(v % DEPTH);
  endfunction

  byte_t            mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [NIB_W-1:0] count_q;

  assign count_o = count_q;

  for (genvar g = 0; g < int'(SLOTS); g++) begin : g_peek
    assign peek_o[g] = (NIB_W'(g) < count_q) ? mem[wrap(int'(rd_ptr) + g)] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
    end else begin
      if (push_i) begin
        mem[wr_ptr] <= push_data_i;
        wr_ptr      <= wrap(int'(wr_ptr) + 1);
      end
      rd_ptr  <= wrap(int'(rd_ptr) + int'(pop_n_i));
      count_q <= count_q + NIB_W'(push_i) - pop_n_i;
    end
  end

  p_pop_le_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_n_i <= count_q);
  p_tx_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= NIB_W'(DEPTH));
endmodule

// File: rtl/jsp_scan_frame.sv
module jsp_scan_frame
  import jsp_pkg::*;
#(
  parameter int unsigned SLOTS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  multi_i,
  input  logic                  sel_i,
  input  logic                  capture_i,
  input  logic                  shift_i,
  input  logic                  update_i,
  input  logic                  tdi_i,
  input  logic [NIB_W-1:0]      avail_i,
  input  logic [NIB_W-1:0]      free_i,
  input  logic [SLOTS-1:0][7:0] tx_bytes_i,
  output logic                  tdo_o,
  output logic                  commit_o,
  output logic [NIB_W-1:0]      host_n_o,
  output logic [SLOTS-1:0][7:0] host_bytes_o,
  output logic [NIB_W-1:0]      avail_cap_o
);
  localparam int unsigned FRAME_BITS = 8 * (SLOTS + 1);
  localparam int unsigned IN_W       = FRAME_BITS - NIB_W;
  localparam int unsigned BC_W       = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] out_sr;
  logic [IN_W-1:0]       in_sr;   // header low nibble is never stored
  logic [BC_W-1:0]       bit_cnt;
  logic                  started;
  logic [NIB_W-1:0]      avail_q;
  logic                  do_cap, do_shift, do_upd;

  assign do_cap   = sel_i && capture_i;
  assign do_shift = sel_i && shift_i;
  assign do_upd   = sel_i && update_i;

  assign tdo_o        = out_sr[0];
  assign commit_o     = do_upd && (bit_cnt == BC_W'(FRAME_BITS));
  assign host_n_o     = nib_min(in_sr[NIB_W-1:0], NIB_W'(SLOTS));
  assign host_bytes_o = in_sr[IN_W-1:NIB_W];
  assign avail_cap_o  = avail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sr  <= '0;
      in_sr   <= '0;
      bit_cnt <= '0;
      started <= 1'b0;
      avail_q <= '0;
    end else if (do_cap) begin
      out_sr  <= {tx_bytes_i, avail_i, free_i};
      bit_cnt <= '0;
      started <= !multi_i;
      avail_q <= avail_i;
    end else if (do_shift) begin
      out_sr <= {1'b0, out_sr[FRAME_BITS-1:1]};
      if (!started) begin
        if (tdi_i) started <= 1'b1;
      end else if (bit_cnt < BC_W'(FRAME_BITS)) begin
        if (bit_cnt >= BC_W'(NIB_W)) in_sr <= {tdi_i, in_sr[IN_W-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end else if (do_upd) begin
      bit_cnt <= '0;
    end
  end

  p_hdr_first_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_cap |=> (tdo_o == $past(free_i[0])));
endmodule

// File: rtl/jsp_console_link.sv
module jsp_console_link
  import jsp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SLOTS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       multi_i,
  input  logic       sel_i,
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  input  logic       tdi_i,
  output logic       tdo_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o
);
  logic [NIB_W-1:0]      rx_cnt, tx_cnt, rx_free, avail, avail_cap, host_n;
  logic [NIB_W-1:0]      rx_push_n, tx_pop_n;
  logic [SLOTS-1:0][7:0] tx_peek, host_bytes;
  logic                  commit, rx_pop, tx_push;

  assign rx_free    = NIB_W'(DEPTH) - rx_cnt;
  assign avail      = nib_min(tx_cnt, NIB_W'(SLOTS));
  assign rx_valid_o = (rx_cnt != '0);
  assign rx_pop     = rx_valid_o && rx_ready_i;
  assign tx_ready_o = (tx_cnt < NIB_W'(DEPTH));
  assign tx_push    = tx_valid_i && tx_ready_o;
  assign rx_push_n  = commit ? nib_min(host_n, rx_free) : '0;
  assign tx_pop_n   = commit ? avail_cap : '0;

  jsp_scan_frame #(.SLOTS(SLOTS)) u_frame (
    .clk_i, .rst_ni, .multi_i, .sel_i, .capture_i, .shift_i, .update_i, .tdi_i,
    .avail_i(avail), .free_i(rx_free), .tx_bytes_i(tx_peek),
    .tdo_o, .commit_o(commit), .host_n_o(host_n), .host_bytes_o(host_bytes),
    .avail_cap_o(avail_cap)
  );

  jsp_rx_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_rx (
    .clk_i, .rst_ni, .push_n_i(rx_push_n), .push_bytes_i(host_bytes),
    .pop_i(rx_pop), .head_o(rx_data_o), .count_o(rx_cnt)
  );

  jsp_tx_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_tx (
    .clk_i, .rst_ni, .push_i(tx_push), .push_data_i(tx_data_i),
    .pop_n_i(tx_pop_n), .peek_o(tx_peek), .count_o(tx_cnt)
  );

  p_rx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && !rx_pop) |=> $stable(rx_cnt));
  p_tx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && !tx_push) |=> $stable(tx_cnt));
  p_full_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt == NIB_W'(DEPTH) && !commit) |=> (tx_cnt == NIB_W'(DEPTH)));
endmodule

// File: tb/jsp_console_link_bench.sv
module jsp_console_link_bench;
  logic clk = 0, rst_n = 0;
  logic multi = 0, sel = 1, cap = 0, sft = 0, upd = 0, tdi = 0;
  logic tdo, rx_valid, rx_ready = 0, tx_valid = 0, tx_ready;
  logic [7:0] rx_data, tx_data = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  jsp_console_link u_jsp_console_link (
    .clk_i(clk), .rst_ni(rst_n), .multi_i(multi), .sel_i(sel),
    .capture_i(cap), .shift_i(sft), .update_i(upd), .tdi_i(tdi), .tdo_o(tdo),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One scan: pre zeros, optional start bit, nbits payload bits, post ones.
  task automatic scan(input logic [71:0] pl, input int pre, input bit start,
                      input int nbits, input int post, output logic [71:0] got);
    bit s [0:199];
    int n = 0;
    for (int i = 0; i < pre; i++) s[n++] = 0;
    if (start) s[n++] = 1;
    for (int i = 0; i < nbits; i++) s[n++] = pl[i];
    for (int i = 0; i < post; i++) s[n++] = 1;
    got = '0;
    @(negedge clk); cap = 1;
    @(negedge clk); cap = 0;
    for (int i = 0; i < n; i++) begin
      sft = 1; tdi = s[i];
      if (i < 72) got[i] = tdo;
      @(negedge clk);
    end
    sft = 0; tdi = 0; upd = 1;
    @(negedge clk); upd = 0;
  endtask

  function automatic logic [71:0] frame(input logic [3:0] cnt, input logic [63:0] d);
    return {d, cnt, 4'h0};
  endfunction

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_valid = 1; tx_data = b;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic expect_rx(input logic [7:0] b, input string req);
    @(negedge clk);
    check(rx_valid === 1'b1, req, "rx_valid", rx_valid, 1);
    check(rx_data === b, req, "rx_data", rx_data, b);
    rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic expect_rx_empty(input string req);
    @(negedge clk);
    check(rx_valid === 1'b0, req, "rx empty", rx_valid, 0);
  endtask

  task automatic t_reset;
    logic [71:0] g;
    check(rx_valid === 1'b0, "R1", "rx_valid", rx_valid, 0);
    check(tx_ready === 1'b1, "R1", "tx_ready", tx_ready, 1);
    scan(frame(0, 0), 0, 0, 72, 0, g);
    check(g[7:0] === 8'h08, "R1", "reset header", g[7:0], 8'h08);
  endtask

  task automatic t_basic;
    logic [71:0] g;
    push_tx(8'hA1); push_tx(8'hB2); push_tx(8'hC3);
    scan(frame(2, 64'h0000_0000_0000_2211), 0, 0, 72, 0, g);
    check(g[7:0] === 8'h38, "R2", "header", g[7:0], 8'h38);
    check(g[15:8] === 8'hA1, "R3", "byte0", g[15:8], 8'hA1);
    check(g[31:24] === 8'hC3, "R3", "byte2", g[31:24], 8'hC3);
    check(g[39:32] === 8'h00, "R3", "unused slot", g[39:32], 0);
    expect_rx(8'h11, "R4"); expect_rx(8'h22, "R4"); expect_rx_empty("R4");
    scan(frame(0, 0), 0, 0, 72, 0, g);
    check(g[7:4] === 4'h0, "R6", "tx popped", g[7:4], 0);
  endtask

  task automatic t_multi;
    logic [71:0] g;
    multi = 1;
    push_tx(8'h5A);
    scan(frame(4, 64'h0000_0000_8C7B_6A59), 3, 1, 72, 1, g);
    check(g[7:0] === 8'h18, "R8", "header not delayed", g[7:0], 8'h18);
    check(g[15:8] === 8'h5A, "R8", "byte0 not delayed", g[15:8], 8'h5A);
    expect_rx(8'h59, "R8"); expect_rx(8'h6A, "R8");
    expect_rx(8'h7B, "R9"); expect_rx(8'h8C, "R9"); expect_rx_empty("R9");
    multi = 0;
  endtask

  task automatic t_truncated;
    logic [71:0] g;
    push_tx(8'h77);
    scan(frame(5, 64'h1111_1111_1111_1111), 0, 0, 40, 0, g);
    expect_rx_empty("R7");
    scan(frame(0, 0), 0, 0, 72, 0, g);
    check(g[7:0] === 8'h18, "R7", "nothing committed", g[7:0], 8'h18);
    check(g[15:8] === 8'h77, "R6", "kept byte", g[15:8], 8'h77);
  endtask

  task automatic t_clamp;
    logic [71:0] g;
    scan(frame(6, 64'h0000_0605_0403_0201), 0, 0, 72, 0, g);
    scan(frame(5, 64'h0000_000B_0A09_0807), 0, 0, 72, 0, g);
    scan(frame(0, 0), 0, 0, 72, 0, g);
    check(g[3:0] === 4'h0, "R5", "free space", g[3:0], 0);
    for (int i = 1; i <= 8; i++) expect_rx(8'(i), "R5");
    expect_rx_empty("R5");
    scan(frame(15, 64'hF8F7_F6F5_F4F3_F2F1), 0, 0, 72, 0, g);
    for (int i = 1; i <= 8; i++) expect_rx(8'hF0 + 8'(i), "R5");
    expect_rx_empty("R5");
  endtask

  task automatic t_unselected;
    logic [71:0] g;
    sel = 0;
    scan(frame(3, 64'h0000_0000_0033_2211), 0, 0, 72, 0, g);
    sel = 1;
    expect_rx_empty("R10");
  endtask

  task automatic t_full;
    logic [71:0] g;
    for (int i = 0; i < 8; i++) push_tx(8'h40 + 8'(i));
    @(negedge clk);
    check(tx_ready === 1'b0, "R11", "tx_ready when full", tx_ready, 0);
    push_tx(8'hEE);
    scan(frame(0, 0), 0, 0, 72, 0, g);
    check(g[7:4] === 4'h8, "R11", "avail", g[7:4], 8);
    check(g[15:8] === 8'h40, "R11", "first", g[15:8], 8'h40);
    check(g[71:64] === 8'h47, "R11", "last", g[71:64], 8'h47);
    scan(frame(0, 0), 0, 0, 72, 0, g);
    check(g[7:4] === 4'h0, "R6", "all popped", g[7:4], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_basic; t_multi; t_truncated; t_clamp; t_unselected; t_full;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule